// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller with Software Force

This block collects up to fifteen interrupt request lines, numbered 1 to 15, for one processor. It delivers to that processor the number of the request that should be serviced next. A line that rises records a pending bit. Software can also raise lines directly through a force register. A mask register selects which lines may reach the processor at all. Each line belongs to one of two priority groups, high or low. The high group always wins over the low group. Inside a group, the highest-numbered line wins.

Software reaches the registers over a plain 32-bit word bus with separate read and write strobes. Reads return data combinationally. Writes take effect on the clock edge. When the processor takes an interrupt, it returns the serviced number on an acknowledge port, and the block drops that line's pending and forced state. Lines that are marked for broadcast do not go to the pending register on a rising edge; they set the force register instead. Only processor 0's mask, force and extended registers exist. Every other per-processor slot reads as zero. The design contains no state machine: all of its state is plain registers updated once per clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and the interrupt number output is 0.
- R2: Bit 0 is never stored. The level (0x00), force (0x08/0x80) and broadcast (0x14) registers keep only bits 15:1. The mask register (0x40) keeps bits 31:1.
- R3: On a sampled rising edge of line n whose broadcast bit is 0, pending bit n (0x04) is set. A line held high after its bit is cleared does not set the bit again.
- R4: On a rising edge of line n whose broadcast bit is 1, force bit n is set and the pending register is unchanged.
- R5: A write to 0x0C clears the written bits 15:1 in both the pending and force registers. 0x0C reads as zero.
- R6: An acknowledge with number n clears bit n in both the pending and force registers. A number of 0 has no effect.
- R7: A write to 0x80 gives force = (force OR data[15:1]) AND NOT data[31:17], where data bit 16+k clears line k.
- R8: A write to 0x08 replaces force with data[15:1], with no set/clear behaviour.
- R9: With active = (pending OR force) AND mask, the output is the highest-numbered active line whose level bit is 1. If no such line exists, it is the highest-numbered active line whose level bit is 0. If no line is active, the output is 0. The output follows the registers within the same cycle.
- R10: The extended register (0xC0) keeps the low 4 bits of a write.
- R11: The status word (0x10) reads zero and ignores writes. Any other unmapped address reads zero, and a write to it changes no register.
- R12: When a rising edge and a clear write or an acknowledge hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 16 | Request lines; bit n is line n, bit 0 ignored |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle bus_rd_i is high |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_num_i | input | 4 | Number of the interrupt being serviced |
| irq_num_o | output | 4 | Selected interrupt number, 0 when none |

## Verification
The hardest case to reach is a collision inside one clock edge. It happens when a line's new rising edge lands in the same cycle as a clear write or an acknowledge for that same bit, so that the set and the clear compete. The stimulus holds the line low for one cycle and then raises it in the same cycle that it drives the clear or acknowledge. A related case is a line that stays high after it has been acknowledged. The stimulus keeps the line asserted through the acknowledge and checks that no new pending bit appears. A cycle-by-cycle model in the bench tracks every register and compares against the design on each clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int MAX_VEC_W = 16;

    typedef logic [MAX_VEC_W-1:0] line_vec_t;

    localparam logic [7:0] OFS_LEVEL  = 8'h00;
    localparam logic [7:0] OFS_PEND   = 8'h04;
    localparam logic [7:0] OFS_ALIAS  = 8'h08;
    localparam logic [7:0] OFS_CLEAR  = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_BCAST  = 8'h14;
    localparam logic [7:0] OFS_MASK0  = 8'h40;
    localparam logic [7:0] OFS_FORCE0 = 8'h80;
    localparam logic [7:0] OFS_EXT0   = 8'hC0;

    // index of the highest set bit above bit 0, zero when none
    function automatic logic [3:0] msb_index(input line_vec_t v);
        logic [3:0] r;
        r = '0;
        for (int i = 1; i < MAX_VEC_W; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_edge_detect.sv
module irqc_edge_detect #(
    parameter int NUM_LINES = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES:0]   lines_i,
    output logic [NUM_LINES:0]   rise_o
);
    localparam logic [NUM_LINES:0] LINE_MASK = {{NUM_LINES{1'b1}}, 1'b0};

    logic [NUM_LINES:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines_i;
    end

    assign rise_o = lines_i & ~prev_q & LINE_MASK;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EXT_W     = 4,
    parameter int NUM_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES:0]   rise_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic                 ack_valid_i,
    input  logic [NUM_W-1:0]     ack_num_i,
    output logic [NUM_LINES:0]   level_o,
    output logic [NUM_LINES:0]   active_o
);
    localparam logic [NUM_LINES:0] LINE_MASK = {{NUM_LINES{1'b1}}, 1'b0};
    localparam int CLR_LSB = 16;

    logic [NUM_LINES:0] level_q, pend_q, force_q, bcast_q;
    logic [DATA_W-1:0]  mask_q;
    logic [EXT_W-1:0]   ext_q;

    logic wr_level, wr_alias, wr_clr, wr_bcast, wr_mask, wr_force, wr_ext;
    logic [NUM_LINES:0] wdata_lines, wdata_clrf, clr_vec, ack_vec;
    logic [NUM_LINES:0] set_pend, set_force, force_base, pend_d, force_d;

    // address decode
    assign wr_level = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_LEVEL));
    assign wr_alias = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_ALIAS));
    assign wr_clr   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_CLEAR));
    assign wr_bcast = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_BCAST));
    assign wr_mask  = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK0));
    assign wr_force = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_FORCE0));
    assign wr_ext   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_EXT0));

    assign wdata_lines = bus_wdata_i[NUM_LINES:0] & LINE_MASK;
    assign wdata_clrf  = bus_wdata_i[CLR_LSB +: NUM_LINES+1] & LINE_MASK;
    assign clr_vec     = wr_clr ? wdata_lines : '0;

    always_comb begin
        ack_vec = '0;
        if (ack_valid_i) ack_vec[ack_num_i] = 1'b1;
        ack_vec = ack_vec & LINE_MASK;
    end

    // rising edges go to pending or, when broadcast-marked, to force
    assign set_pend  = rise_i & ~bcast_q & LINE_MASK;
    assign set_force = rise_i & bcast_q & LINE_MASK;

    always_comb begin
        if (wr_alias)      force_base = wdata_lines;
        else if (wr_force) force_base = (force_q | wdata_lines) & ~wdata_clrf;
        else               force_base = force_q;
        // clears first, then sets, so a same-cycle set survives
        force_d = (force_base & ~clr_vec & ~ack_vec) | set_force;
        pend_d  = (pend_q & ~clr_vec & ~ack_vec) | set_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            pend_q  <= '0;
            force_q <= '0;
            bcast_q <= '0;
            mask_q  <= '0;
            ext_q   <= '0;
        end else begin
            pend_q  <= pend_d;
            force_q <= force_d;
            if (wr_level) level_q <= wdata_lines;
            if (wr_bcast) bcast_q <= wdata_lines;
            if (wr_mask)  mask_q  <= {bus_wdata_i[DATA_W-1:1], 1'b0};
            if (wr_ext)   ext_q   <= bus_wdata_i[EXT_W-1:0];
        end
    end

    // read mux; status, clear and unmapped words read zero
    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (bus_addr_i)
                ADDR_W'(OFS_LEVEL):  bus_rdata_o = DATA_W'(level_q);
                ADDR_W'(OFS_PEND):   bus_rdata_o = DATA_W'(pend_q);
                ADDR_W'(OFS_ALIAS):  bus_rdata_o = DATA_W'(force_q);
                ADDR_W'(OFS_BCAST):  bus_rdata_o = DATA_W'(bcast_q);
                ADDR_W'(OFS_MASK0):  bus_rdata_o = mask_q;
                ADDR_W'(OFS_FORCE0): bus_rdata_o = DATA_W'(force_q);
                ADDR_W'(OFS_EXT0):   bus_rdata_o = DATA_W'(ext_q);
                default:             bus_rdata_o = '0;
            endcase
        end
    end

    assign level_o  = level_q;
    assign active_o = (pend_q | force_q) & mask_q[NUM_LINES:0];

    // R3: a non-broadcast rising edge leaves its pending bit set
    p_rise_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pend) |=> ((pend_q & $past(set_pend)) == $past(set_pend)));

    // R4: a broadcast rising edge leaves its force bit set
    p_bcast_sets_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_force) |=> ((force_q & $past(set_force)) == $past(set_force)));

    // R5: a clear write empties the written pending bits unless re-raised
    p_clear_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pend_q & $past(wdata_lines & ~rise_i)) == '0));

    // R6: acknowledge drops the bit from both registers
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ack_vec) && ((ack_vec & rise_i) == '0))
        |=> (((pend_q | force_q) & $past(ack_vec)) == '0));

    // R7: set/clear word on the per-processor force register
    p_force_setclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_force && !ack_valid_i && (rise_i == '0))
        |=> (force_q == (($past(force_q) | $past(wdata_lines)) & ~$past(wdata_clrf))));

    // R12: a rising edge wins against a same-cycle acknowledge
    p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(ack_vec & set_pend))) |=> ((pend_q & $past(ack_vec & set_pend)) != '0));

endmodule

// File: rtl/irqc_prio_sel.sv
module irqc_prio_sel
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int NUM_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES:0]   active_i,
    input  logic [NUM_LINES:0]   level_i,
    output logic [NUM_W-1:0]     irq_num_o
);
    localparam int N_GRP = 2;   // group 0 = low level, group 1 = high level

    logic [NUM_LINES:0] grp_vec [N_GRP];
    logic [NUM_W-1:0]   grp_num [N_GRP];
    logic [N_GRP-1:0]   grp_any;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        if (g == 0) begin : g_low
            assign grp_vec[g] = active_i & ~level_i;
        end else begin : g_high
            assign grp_vec[g] = active_i & level_i;
        end
        assign grp_any[g] = |grp_vec[g];
        assign grp_num[g] = NUM_W'(msb_index(line_vec_t'(grp_vec[g])));
    end

    assign irq_num_o = grp_any[1] ? grp_num[1] : grp_num[0];

    // R9: the reported line is actually active
    p_num_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_num_o != '0) |-> active_i[irq_num_o]);

    // R9: a high-level line is chosen whenever one is active
    p_high_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(active_i & level_i)) |-> level_i[irq_num_o]);

    // R9: nothing active means number zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i == '0) |-> (irq_num_o == '0));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_LINES = 15,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int EXT_W     = 4,
    parameter int NUM_W     = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES:0]   irq_lines_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic                 ack_valid_i,
    input  logic [NUM_W-1:0]     ack_num_i,
    output logic [NUM_W-1:0]     irq_num_o
);
    logic [NUM_LINES:0] rise, level, active;

    irqc_edge_detect #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (irq_lines_i),
        .rise_o  (rise)
    );

    irqc_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .EXT_W     (EXT_W),
        .NUM_W     (NUM_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (rise),
        .bus_wr_i    (bus_wr_i),
        .bus_rd_i    (bus_rd_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .ack_valid_i (ack_valid_i),
        .ack_num_i   (ack_num_i),
        .level_o     (level),
        .active_o    (active)
    );

    irqc_prio_sel #(.NUM_LINES(NUM_LINES), .NUM_W(NUM_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .level_i   (level),
        .irq_num_o (irq_num_o)
    );

endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_num = '0;
    logic [3:0]  irq_num;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_lines_i (irq_lines),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ack_valid_i (ack_valid),
        .ack_num_i   (ack_num),
        .irq_num_o   (irq_num)
    );

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_level, m_pend, m_force, m_bcast, m_prev;
    bit [31:0] m_mask;
    bit [3:0]  m_ext;

    function automatic int model_num();
        int hi = 0, lo = 0;
        for (int i = 1; i < 16; i++) begin
            if ((m_pend[i] || m_force[i]) && m_mask[i]) begin
                if (m_level[i]) hi = i; else lo = i;
            end
        end
        return (hi != 0) ? hi : lo;
    endfunction

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h00: return {16'h0, m_level};
            8'h04: return {16'h0, m_pend};
            8'h08: return {16'h0, m_force};
            8'h14: return {16'h0, m_bcast};
            8'h40: return m_mask;
            8'h80: return {16'h0, m_force};
            8'hC0: return {28'h0, m_ext};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_level = 0; m_pend = 0; m_force = 0; m_bcast = 0;
            m_prev = 0; m_mask = 0; m_ext = 0;
        end else begin
            bit [15:0] np, nf;
            np = m_pend;
            nf = m_force;
            if (bus_wr && bus_addr == 8'h08) nf = bus_wdata[15:0] & 16'hFFFE;
            if (bus_wr && bus_addr == 8'h80)
                nf = (nf | (bus_wdata[15:0] & 16'hFFFE)) & ~(bus_wdata[31:16] & 16'hFFFE);
            for (int i = 1; i < 16; i++) begin
                bit rose;
                rose = irq_lines[i] && !m_prev[i];
                if (bus_wr && bus_addr == 8'h0C && bus_wdata[i]) begin
                    np[i] = 0; nf[i] = 0;
                end
                if (ack_valid && ack_num == i) begin
                    np[i] = 0; nf[i] = 0;
                end
                if (rose) begin
                    if (m_bcast[i]) nf[i] = 1; else np[i] = 1;
                end
            end
            if (bus_wr && bus_addr == 8'h00) m_level = bus_wdata[15:0] & 16'hFFFE;
            if (bus_wr && bus_addr == 8'h14) m_bcast = bus_wdata[15:0] & 16'hFFFE;
            if (bus_wr && bus_addr == 8'h40) m_mask = bus_wdata & 32'hFFFF_FFFE;
            if (bus_wr && bus_addr == 8'hC0) m_ext = bus_wdata[3:0];
            m_pend = np;
            m_force = nf;
            m_prev = irq_lines;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R9 output, reads for all registers)
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R9 model irq_num", {28'h0, irq_num}, model_num());
            if (bus_rd) chk("R11 model read", bus_rdata, model_read(bus_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int n);
        irq_lines[n] = 1'b1;
        step();
        irq_lines[n] = 1'b0;
    endtask

    task automatic ack(input int n);
        ack_valid = 1'b1; ack_num = 4'(n);
        step();
        ack_valid = 1'b0;
    endtask

    task automatic num_chk(input int exp, input string tag);
        chk(tag, {28'h0, irq_num}, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        num_chk(0, "R1 irq_num after reset");
        rd_chk(8'h00, 0, "R1 level");
        rd_chk(8'h04, 0, "R1 pending");
        rd_chk(8'h40, 0, "R1 mask");

        // R2 bit 0 and upper bits dropped
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_FFFE, "R2 level width");
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk(8'h40, 32'hFFFF_FFFE, "R2 mask width");
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, 32'h0000_FFFE, "R2 broadcast width");
        wr(8'h14, 0);
        wr(8'h00, 32'h0000_0100);   // line 8 high level

        // R3 / R9 pending and priority
        pulse(3);
        rd_chk(8'h04, 32'h0008, "R3 pending after edge");
        num_chk(3, "R9 single line");
        pulse(5);
        num_chk(5, "R9 higher number wins");
        pulse(8);
        num_chk(8, "R9 high level line");
        irq_lines[9] = 1'b1;
        step();
        num_chk(8, "R9 high group beats higher low number");
        wr(8'h0C, 32'h0000_0100);
        num_chk(9, "R9 low group after high cleared");
        ack(9);
        num_chk(5, "R6 ack drops line 9");
        rd_chk(8'h04, 32'h0028, "R3 held line not re-pended");
        irq_lines[9] = 1'b0;
        step();

        // R9 masking
        wr(8'h40, 32'h0000_0008);
        num_chk(3, "R9 mask selects line 3");
        wr(8'h40, 0);
        num_chk(0, "R9 all masked");
        wr(8'h40, 32'hFFFF_FFFE);

        // R5 clear register
        wr(8'h0C, 32'h0000_FFFF);
        rd_chk(8'h04, 0, "R5 clear pending");
        rd_chk(8'h0C, 0, "R5 clear reads zero");

        // R7 set/clear force, R8 alias
        wr(8'h80, 32'h0000_0022);
        rd_chk(8'h08, 32'h0022, "R7 force set via alias read");
        num_chk(5, "R7 forced line drives output");
        wr(8'h80, 32'h0020_0040);
        rd_chk(8'h80, 32'h0042, "R7 set and clear fields");
        num_chk(6, "R7 output after set/clear");
        wr(8'h08, 32'h0001_0011);
        rd_chk(8'h80, 32'h0010, "R8 alias replaces");
        num_chk(4, "R8 output after alias");

        // R4 broadcast routing
        wr(8'h14, 32'h0000_0400);
        pulse(10);
        rd_chk(8'h80, 32'h0410, "R4 broadcast sets force");
        rd_chk(8'h04, 0, "R4 pending untouched");
        num_chk(10, "R4 output");
        ack(10);
        rd_chk(8'h80, 32'h0010, "R6 ack clears force");
        wr(8'h0C, 32'h0000_0010);
        rd_chk(8'h08, 0, "R5 clear hits force");
        wr(8'h14, 0);
        ack(0);
        num_chk(0, "R6 ack of zero harmless");

        // R12 set wins
        irq_lines[7] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0080;
        step();
        bus_wr = 1'b0;
        rd_chk(8'h04, 32'h0080, "R12 edge beats clear write");
        irq_lines[7] = 1'b0;
        step();
        wr(8'h0C, 32'h0000_0080);
        irq_lines[7] = 1'b1;
        ack_valid = 1'b1; ack_num = 4'd7;
        step();
        ack_valid = 1'b0;
        rd_chk(8'h04, 32'h0080, "R12 edge beats ack");
        ack(7);
        rd_chk(8'h04, 0, "R6 ack with line held");
        irq_lines[7] = 1'b0;
        step();

        // R10 extended
        wr(8'hC0, 32'hFFFF_FFFF);
        rd_chk(8'hC0, 32'h0000_000F, "R10 extended width");

        // R11 status and unmapped
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h10, 0, "R11 status reads zero");
        wr(8'h44, 32'h0000_0008);
        rd_chk(8'h40, 32'hFFFF_FFFE, "R11 unmapped write ignored");
        rd_chk(8'h44, 0, "R11 unmapped read");
        rd_chk(8'h84, 0, "R11 other force slot reads zero");

        // R1 reset mid-run
        wr(8'h80, 32'h0000_0004);
        rst_n = 1'b0;
        step();
        num_chk(0, "R1 irq_num in reset");
        rst_n = 1'b1;
        step();
        rd_chk(8'h80, 0, "R1 force after reset");
        rd_chk(8'hC0, 0, "R1 extended after reset");
        rd_chk(8'h40, 0, "R1 mask after reset");

        summary();
        $finish;
    end

endmodule